// File: doc/BRIEF.md
# Clock Mode and Stop Controller

This block derives a set of system clocks from a single fast base clock. It drives a group of CPU clock outputs, a group of gated PCI clock outputs, one free-running PCI clock output and a reference clock output. Two select pins choose the mode: outputs released to high impedance, low-speed active, test, or high-speed active. All clock outputs are registered levels at base-clock rate. The high-impedance state is reported through an output-enable flag for the pad drivers.

Three active-low controls stop the CPU group, stop the gated PCI group, or power the whole block down. Every control passes through a two-flop synchronizer. A stop is applied only while the affected clock is low, so no output ever carries a shortened pulse. Power-down freezes the dividers and holds every output low. On release, outputs stay low for a parameterised settling count. A change of the select pins resets the dividers to phase zero and holds the outputs low for one full PCI period of the new mode.

The CPU clock is always half the base clock. The PCI divider is 6 in high-speed and test modes and 4 in low-speed mode. Each PCI rising edge therefore coincides with a CPU rising edge, and the CPU/PCI ratio is 3 or 2. The reset input is expected to arrive already released in step with the clock.

Top module: `clkmode_ctrl`

## Requirements
- R1: `sel_i` is decoded as follows: 2'b00 selects high impedance, 2'b01 low-speed, 2'b10 test and 2'b11 high-speed. `oe_o` is 0 in high impedance and 1 in the other three modes. It follows a stable select value 3 clock edges after the change.
- R2: In every mode, each enabled CPU output is high for exactly one base cycle and low for the next. All CPU outputs carry the same level.
- R3: `pci_free_o` has a period of 6 base cycles (3 high, 3 low) in the high-speed, test and high-impedance modes, and 4 cycles (2 high, 2 low) in low-speed mode. Each of its rising edges coincides with a rising edge of every enabled CPU output.
- R4: `ref_o` passes `osc_i` through in the non-test modes. In test mode it equals the base clock level.
- R5: While `cpu_stop_ni` is 0, the CPU outputs are held low. Asserting or releasing it takes effect no later than the second `pci_free_o` rising edge after the change. Every CPU pulse keeps its full width.
- R6: While `pci_stop_ni` is 0, the gated PCI outputs are held low and `pci_free_o` keeps toggling. The same latency as R5 applies. A gated PCI output rises and falls only together with `pci_free_o`.
- R7: When `pwr_ni` is 0, every clock output, including `ref_o`, is low from the third clock edge after the change (well inside two `pci_free_o` edges). The dividers stop.
- R8: After `pwr_ni` returns to 1, the outputs stay low for SETTLE_CYC cycles. The first `pci_free_o` rise comes at edge SETTLE_CYC+2 after the change, together with a CPU rise.
- R9: After a select change, all outputs are low from edge 3 after the change for one full PCI period of the new mode. At edge 3+period, `pci_free_o` and the CPU outputs rise together.
- R10: While reset is active, all clock outputs and `oe_o` are 0. Leaving reset counts as a power-up: outputs stay low for at least SETTLE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock (also the test clock in test mode) |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| sel_i | input | 2 | Mode select |
| cpu_stop_ni | input | 1 | Active-low CPU clock stop |
| pci_stop_ni | input | 1 | Active-low gated PCI clock stop |
| pwr_ni | input | 1 | Active-low power-down |
| osc_i | input | 1 | Reference oscillator level |
| cpu_o | output | N_CPU | CPU clock outputs |
| pci_o | output | N_PCI | Gated PCI clock outputs |
| pci_free_o | output | 1 | Free-running PCI clock |
| ref_o | output | 1 | Reference clock output |
| oe_o | output | 1 | Output enable for all clock pads |

## Verification
The bench builds the block with N_CPU=2, N_PCI=5 and default dividers, but shrinks SETTLE_CYC to 16. The settling window after power-up and reset then closes in a few dozen cycles, so the exact first-edge timing of R8 can be checked directly instead of waiting through a realistic multi-millisecond count. Keeping two CPU and five PCI outputs exercises the generated gate instances for agreement between copies.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  typedef enum logic [1:0] {
    MODE_TRI  = 2'b00,
    MODE_LO   = 2'b01,
    MODE_TEST = 2'b10,
    MODE_HI   = 2'b11
  } mode_e;

  // PCI divider for a mode: low-speed uses the low divider, all others the high one
  function automatic int unsigned pci_div(mode_e m, int unsigned hi, int unsigned lo);
    return (m == MODE_LO) ? lo : hi;
  endfunction

endpackage

// File: rtl/clkmode_sync.sv
module clkmode_sync #(
  parameter int unsigned            WIDTH   = 1,
  parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] ff1_q;
  logic [WIDTH-1:0] ff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= RST_VAL;
      ff2_q <= RST_VAL;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end

  assign q_o = ff2_q;

endmodule

// File: rtl/clkmode_phase.sv
module clkmode_phase
  import clkmode_pkg::*;
#(
  parameter int unsigned DIV_HI     = 6,
  parameter int unsigned DIV_LO     = 4,
  parameter int unsigned SETTLE_CYC = 600000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  pwr_ok_i,
  output mode_e mode_o,
  output logic  run_o,
  output logic  cpu_nx_o,
  output logic  pci_nx_o
);

  localparam int unsigned MAX_DIV = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int          DW      = $clog2(MAX_DIV + 1);
  localparam int          SW      = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LD = SW'(SETTLE_CYC);

  mode_e          mode_q, mode_d;
  logic [DW-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]  hold_q, hold_d;
  logic [SW-1:0]  settle_q, settle_d;
  logic           run_q, run_d;
  logic           mode_chg;
  logic [DW-1:0]  div_q, div_d, half_d;
  logic           settle_en;

  // next-state: mode change has priority, then power-down, settling, hold, run
  always_comb begin
    mode_d    = mode_q;
    cnt_d     = '0;
    hold_d    = hold_q;
    settle_d  = settle_q;
    settle_en = 1'b0;
    mode_chg  = (mode_i != mode_q);
    div_q     = DW'(pci_div(mode_q, DIV_HI, DIV_LO));
    if (mode_chg) begin
      mode_d = mode_i;
      hold_d = DW'(pci_div(mode_i, DIV_HI, DIV_LO));
    end else if (!pwr_ok_i) begin
      settle_en = 1'b1;
      settle_d  = SETTLE_LD;
    end else if (settle_q != '0) begin
      settle_en = 1'b1;
      settle_d  = settle_q - SW'(1);
    end else if (hold_q != '0) begin
      hold_d = hold_q - DW'(1);
    end else if (cnt_q != (div_q - DW'(1))) begin
      cnt_d = cnt_q + DW'(1);
    end
    run_d    = !mode_chg && pwr_ok_i && (settle_d == '0) && (hold_d == '0);
    div_d    = DW'(pci_div(mode_d, DIV_HI, DIV_LO));
    half_d   = div_d >> 1;
    cpu_nx_o = run_d & ~cnt_d[0];
    pci_nx_o = run_d & (cnt_d < half_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_TRI;
      cnt_q  <= '0;
      hold_q <= '0;
      run_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      run_q  <= run_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= SETTLE_LD;
    end else if (settle_en) begin
      settle_q <= settle_d;
    end
  end

  assign mode_o = mode_q;
  assign run_o  = run_q;

endmodule

// File: rtl/clkmode_gate.sv
module clkmode_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_nx_i,
  input  logic run_i,
  output logic en_o,
  output logic clk_o
);

  logic en_q, en_d, en_upd;
  logic out_q, out_d;

  // enable may only change in a cycle whose output level is low
  always_comb begin
    en_upd = !lvl_nx_i;
    en_d   = run_i;
    out_d  = lvl_nx_i & en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (en_upd) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
    end
  end

  assign en_o  = en_q;
  assign clk_o = out_q;

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int unsigned N_CPU      = 2,
  parameter int unsigned N_PCI      = 5,
  parameter int unsigned DIV_HI     = 6,
  parameter int unsigned DIV_LO     = 4,
  parameter int unsigned SETTLE_CYC = 600000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  input  logic             pwr_ni,
  input  logic             osc_i,
  output logic [N_CPU-1:0] cpu_o,
  output logic [N_PCI-1:0] pci_o,
  output logic             pci_free_o,
  output logic             ref_o,
  output logic             oe_o
);

  logic [1:0]       sel_s;
  logic [2:0]       ctl_s;
  mode_e            mode_w;
  logic             run_w;
  logic             cpu_nx, pci_nx;
  logic             pci_free_q;
  logic [N_CPU-1:0] cpu_en_w;
  logic [N_PCI-1:0] pci_en_w;

  clkmode_sync #(.WIDTH(2), .RST_VAL(2'b00)) u_sel_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sel_i),
    .q_o    (sel_s)
  );

  // bit 2: power ok, bit 1: PCI run, bit 0: CPU run
  clkmode_sync #(.WIDTH(3), .RST_VAL(3'b000)) u_ctl_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pwr_ni, pci_stop_ni, cpu_stop_ni}),
    .q_o    (ctl_s)
  );

  clkmode_phase #(
    .DIV_HI     (DIV_HI),
    .DIV_LO     (DIV_LO),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_e'(sel_s)),
    .pwr_ok_i (ctl_s[2]),
    .mode_o   (mode_w),
    .run_o    (run_w),
    .cpu_nx_o (cpu_nx),
    .pci_nx_o (pci_nx)
  );

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    clkmode_gate u_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lvl_nx_i (cpu_nx),
      .run_i    (ctl_s[0]),
      .en_o     (cpu_en_w[g]),
      .clk_o    (cpu_o[g])
    );
  end

  for (genvar g = 0; g < N_PCI; g++) begin : g_pci
    clkmode_gate u_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lvl_nx_i (pci_nx),
      .run_i    (ctl_s[1]),
      .en_o     (pci_en_w[g]),
      .clk_o    (pci_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pci_free_q <= 1'b0;
    end else begin
      pci_free_q <= pci_nx;
    end
  end

  assign pci_free_o = pci_free_q;
  assign ref_o      = run_w & ((mode_w == MODE_TEST) ? clk_i : osc_i);
  assign oe_o       = (mode_w != MODE_TRI);

endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk #(
  parameter int unsigned N_CPU = 2,
  parameter int unsigned N_PCI = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       sel_i,
  input logic             pwr_ni,
  input logic [N_CPU-1:0] cpu_o,
  input logic [N_PCI-1:0] pci_o,
  input logic             pci_free_o,
  input logic             ref_o,
  input logic             oe_o,
  input logic [N_CPU-1:0] cpu_en
);

  logic [2:0] cyc_q;
  logic       cyc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
    end else if (cyc_q != 3'd7) begin
      cyc_q <= cyc_q + 3'd1;
    end
  end

  assign cyc_ok = (cyc_q >= 3'd4);

  AST_SEL_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_ok && sel_i == $past(sel_i) && sel_i == $past(sel_i, 2) && sel_i == $past(sel_i, 3))
      |-> (oe_o == (sel_i != 2'b00))); // R1

  AST_CPU_ONE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_ok && cpu_o[0]) |=> !cpu_o[0]); // R2

  AST_PCI_CPU_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_ok && $rose(pci_free_o) && cpu_en[0]) |-> cpu_o[0]); // R3

  AST_CPU_GATED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_ok && !$past(cpu_en[0])) |-> !cpu_o[0]); // R5

  AST_PCI_RISE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_ok && $rose(pci_o[0])) |-> $rose(pci_free_o)); // R6

  AST_PCI_FALL_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_ok && $fell(pci_o[0])) |-> $fell(pci_free_o)); // R6

  AST_PWRDN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_ok && !pwr_ni && !$past(pwr_ni) && !$past(pwr_ni, 2) && !$past(pwr_ni, 3))
      |-> (cpu_o == '0 && pci_o == '0 && !pci_free_o && !ref_o)); // R7

endmodule

bind clkmode_ctrl clkmode_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .pwr_ni     (pwr_ni),
  .cpu_o      (cpu_o),
  .pci_o      (pci_o),
  .pci_free_o (pci_free_o),
  .ref_o      (ref_o),
  .oe_o       (oe_o),
  .cpu_en     (cpu_en_w)
);

// File: tb/clkmode_ctrl_tb_top.sv
module clkmode_ctrl_tb_top;

  localparam int NC     = 2;
  localparam int NP     = 5;
  localparam int SETTLE = 16;

  typedef struct packed {
    logic [1:0] sel;
    logic       cs;
    logic       ps;
    logic       oe;
    logic [7:0] cpu_r;
    logic [7:0] pci_r;
    logic [7:0] fr_r;
  } vec_t;

  // 24-cycle windows: CPU 12 rises, PCI 4 (div 6) or 6 (div 4)
  localparam vec_t VECS [0:8] = '{
    '{2'b11, 1'b1, 1'b1, 1'b1, 8'd12, 8'd4, 8'd4},
    '{2'b11, 1'b0, 1'b1, 1'b1, 8'd0,  8'd4, 8'd4},
    '{2'b11, 1'b1, 1'b0, 1'b1, 8'd12, 8'd0, 8'd4},
    '{2'b11, 1'b0, 1'b0, 1'b1, 8'd0,  8'd0, 8'd4},
    '{2'b01, 1'b1, 1'b1, 1'b1, 8'd12, 8'd6, 8'd6},
    '{2'b01, 1'b0, 1'b1, 1'b1, 8'd0,  8'd6, 8'd6},
    '{2'b01, 1'b1, 1'b0, 1'b1, 8'd12, 8'd0, 8'd6},
    '{2'b10, 1'b1, 1'b1, 1'b1, 8'd12, 8'd4, 8'd4},
    '{2'b00, 1'b1, 1'b1, 1'b0, 8'd12, 8'd4, 8'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    sel;
  logic          cpu_stop_n, pci_stop_n, pwr_n;
  logic          osc = 1'b0;
  logic [NC-1:0] cpu_o;
  logic [NP-1:0] pci_o;
  logic          pci_free_o, ref_o, oe_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int m_cpu, m_pci, m_fr, m_aln, m_ref, m_bits;
  logic m_oe;

  always #4 clk = ~clk;
  always #28 osc = ~osc;

  clkmode_ctrl #(
    .N_CPU(NC), .N_PCI(NP), .SETTLE_CYC(SETTLE)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .cpu_stop_ni(cpu_stop_n),
    .pci_stop_ni(pci_stop_n), .pwr_ni(pwr_n), .osc_i(osc),
    .cpu_o(cpu_o), .pci_o(pci_o), .pci_free_o(pci_free_o),
    .ref_o(ref_o), .oe_o(oe_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit all_low();
    return (cpu_o == '0) && (pci_o == '0) && !pci_free_o && !ref_o;
  endfunction

  task automatic measure(input bit tmode, input bit cpu_on);
    logic pc, pp, pf;
    m_cpu = 0; m_pci = 0; m_fr = 0; m_aln = 0; m_ref = 0; m_bits = 0;
    @(negedge clk); #2;
    pc = cpu_o[0]; pp = pci_o[0]; pf = pci_free_o; m_oe = oe_o;
    for (int i = 0; i < 24; i++) begin
      @(posedge clk); #2;
      if (ref_o !== (tmode ? 1'b1 : osc)) m_ref++;
      @(negedge clk); #2;
      if (ref_o !== (tmode ? 1'b0 : osc)) m_ref++;
      if (cpu_o[0] && !pc) m_cpu++;
      if (pci_o[0] && !pp) m_pci++;
      if (pci_free_o && !pf) begin
        m_fr++;
        if (cpu_on && !cpu_o[0]) m_aln++;
      end
      if (cpu_o != {NC{cpu_o[0]}} || pci_o != {NP{pci_o[0]}}) m_bits++;
      pc = cpu_o[0]; pp = pci_o[0]; pf = pci_free_o;
    end
  endtask

  task automatic stop_lat(input bit on_pci, input string tag);
    logic pf, pg, g;
    int fr, late, first;
    @(negedge clk); #1;
    if (on_pci) pci_stop_n = 1'b0; else cpu_stop_n = 1'b0;
    pf = pci_free_o; pg = on_pci ? pci_o[0] : cpu_o[0]; fr = 0; late = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1;
      g = on_pci ? pci_o[0] : cpu_o[0];
      if (pci_free_o && !pf) fr++;
      if (g && !pg && fr >= 2) late++;
      pf = pci_free_o; pg = g;
    end
    chk(late == 0, tag, "rise after stop latency", late, 0);
    if (on_pci) chk(fr >= 4, "R6", "free PCI rises while stopped", fr, 5);
    if (on_pci) pci_stop_n = 1'b1; else cpu_stop_n = 1'b1;
    fr = 0; first = -1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1;
      g = on_pci ? pci_o[0] : cpu_o[0];
      if (pci_free_o && !pf) fr++;
      if (g && !pg && first < 0) first = fr;
      pf = pci_free_o; pg = g;
    end
    chk(first >= 0 && first <= 2, tag, "free edges before restart", first, 2);
  endtask

  initial begin
    int bad, n;
    logic pf, cpu_at;
    rst_n = 1'b0; sel = 2'b11; cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwr_n = 1'b1;

    // R10: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(all_low(), "R10", "outputs low in reset", int'(pci_free_o), 0);
    chk(!oe_o, "R10", "oe in reset", int'(oe_o), 0);
    rst_n = 1'b1;
    bad = 0;
    for (int k = 1; k <= SETTLE; k++) begin
      @(negedge clk); #1;
      if (pci_free_o || cpu_o != '0 || pci_o != '0) bad++;
    end
    chk(bad == 0, "R10", "outputs low during power-up settle", bad, 0);
    repeat (40) @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < 9; v++) begin
      @(negedge clk); #1;
      sel = VECS[v].sel; cpu_stop_n = VECS[v].cs; pci_stop_n = VECS[v].ps;
      repeat (40) @(negedge clk);
      measure(VECS[v].sel == 2'b10, VECS[v].cs);
      chk(m_oe == VECS[v].oe, "R1", "oe", int'(m_oe), int'(VECS[v].oe));
      chk(m_cpu == int'(VECS[v].cpu_r), VECS[v].cs ? "R2" : "R5", "CPU rises", m_cpu, int'(VECS[v].cpu_r));
      chk(m_pci == int'(VECS[v].pci_r), "R6", "gated PCI rises", m_pci, int'(VECS[v].pci_r));
      chk(m_fr == int'(VECS[v].fr_r), "R3", "free PCI rises", m_fr, int'(VECS[v].fr_r));
      chk(m_aln == 0, "R3", "PCI rise without CPU rise", m_aln, 0);
      chk(m_ref == 0, "R4", "reference mismatches", m_ref, 0);
      chk(m_bits == 0, "R2", "output copies disagree", m_bits, 0);
    end

    @(negedge clk); #1;
    sel = 2'b11; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    repeat (40) @(negedge clk);

    // R7: power-down
    #1;
    pwr_n = 1'b0; pf = pci_free_o; n = 0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); #1;
      if (pci_free_o && !pf) n++;
      pf = pci_free_o;
    end
    chk(all_low(), "R7", "all low at third edge", int'(pci_free_o), 0);
    chk(n <= 2, "R7", "free edges before stop", n, 2);
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); #1;
      if (!all_low()) bad++;
    end
    chk(bad == 0, "R7", "held low in power-down", bad, 0);

    // R8: settle after power-up
    pwr_n = 1'b1; n = -1; cpu_at = 1'b0;
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk); #1;
      if (n < 0 && pci_free_o) begin
        n = k; cpu_at = cpu_o[0];
      end
    end
    chk(n == SETTLE + 2, "R8", "first free PCI edge after power-up", n, SETTLE + 2);
    chk(cpu_at, "R8", "CPU rises with first PCI", int'(cpu_at), 1);

    // R5 and R6: stop latency
    stop_lat(1'b0, "R5");
    stop_lat(1'b1, "R6");

    // R9: mode change 11 -> 01 (new period 4)
    repeat (10) @(negedge clk);
    #1;
    sel = 2'b01; bad = 0; cpu_at = 1'b0; pf = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk); #1;
      if (k >= 3 && k <= 6 && (cpu_o != '0 || pci_o != '0 || pci_free_o)) bad++;
      if (k == 7) begin
        pf = pci_free_o; cpu_at = cpu_o[0];
      end
    end
    chk(bad == 0, "R9", "low during mode-change hold", bad, 0);
    chk(pf && cpu_at, "R9", "restart at edge 3+period", int'(pf && cpu_at), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule